// File: doc/BRIEF.md
# Timestamped Sample Capture FIFO

This block is one capture channel placed after an analog-to-digital converter. Each converted 14-bit sample that arrives with its valid strobe is joined to the value of a free-running capture timer. The joined 32-bit word is placed in a four-entry first-in first-out buffer. Software, or a DMA engine, drains the buffer through a small register port that uses a valid strobe and a word address. A read of the data address removes the oldest word.

Four sticky event bits record buffer events: a sample dropped because the buffer was full, a data read while the buffer was empty, the buffer becoming empty, and the buffer becoming full. Software clears each bit by writing 1 to it. A per-bit enable mask selects which events drive the single interrupt line. When the channel is in DMA mode, a request output stays high while the buffer holds data. A flush command empties the buffer, clears every event bit and restarts the timer.

Register map (word address on `reg_addr`): 0 control (bit 0 flush when written 1, reads 0; bit 1 DMA mode), 1 timer setup (bit 25 run, bit 24 zero the count when written 1, reads 0; bits 16:0 wrap limit), 2 timer count, 3 data pop, 4 fill level, 5 event enable, 6 event status. Address 7 reads 0.

Top module: `tsfifo_chan`

## Requirements
- R1: The buffer holds up to 4 words and returns them in arrival order. `fill_level` and a read of address 4 both give the current word count, from 0 to 4.
- R2: A data word carries the sample in bits [13:0] and, in bits [31:14], the timer count held in the cycle the sample was accepted. The stamp is zero-extended from 17 bits, so bit 31 is 0.
- R3: While setup bit 25 is 1, the timer advances by one each cycle from 0 up to the wrap limit and then returns to 0. While bit 25 is 0 the count holds. Writing 1 to bit 24 zeroes the count. Only the low 17 bits of the limit field are kept, so setup bits 23:17 have no effect. Reading address 2 gives the count.
- R4: A sample that arrives while the buffer is full, with no pop in the same cycle, is dropped and sets status bit 3 (overflow). A sample that arrives together with a pop while the buffer is full is stored.
- R5: A read of address 3 while the buffer is empty returns 0, leaves the level at 0 and sets status bit 2 (underflow).
- R6: Status bit 1 (empty) is set only in the cycle the count moves from nonzero to 0. Status bit 0 (full) is set only in the cycle the count reaches 4.
- R7: Writing 1 to a bit of address 6 clears that status bit, and a read in the next cycle shows it cleared. Writing 0 to a bit leaves it unchanged.
- R8: When an event sets a status bit in the same cycle that a write clears it, the bit stays set.
- R9: `irq` is high when any status bit is 1 and its enable bit at address 5 is also 1. The enable bits use the same order as the status bits.
- R10: `dma_req` is high when control bit 1 is 1 and the fill level is nonzero. Otherwise it is low.
- R11: Writing 1 to control bit 0 empties the buffer, clears all status bits and zeroes the timer count. A sample that arrives in the same cycle is discarded.
- R12: After reset the level, status, enables, DMA mode, timer run bit and timer count are 0, and the wrap limit is 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A converted sample is present this cycle |
| smp_data | input | 14 | Converted sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when the address is 3) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| irq | output | 1 | Interrupt line for enabled events |
| dma_req | output | 1 | DMA request while data is waiting in DMA mode |
| fill_level | output | 3 | Current word count |

## Verification
A wrong pointer or count shows at once on `fill_level` and `dma_req`, and on the next data read as a word in the wrong order or with the wrong stamp. A wrong event bit shows on `irq` one cycle after the event when its enable is set, or on the next status read when it is not. The bench compares the outputs with a behavioural model on every clock. So a fault in timer, buffer or status state is reported in the first cycle it reaches a port, and not at the end of a test phase.

// File: rtl/tsfifo_chan.sv
module tsfifo_chan #(
  parameter int SMP_W  = 14,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int TMR_W  = 17,
  parameter int CFG_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_req,
  output logic [$clog2(DEPTH+1)-1:0] fill_level
);
  localparam int STAMP_W = WORD_W - SMP_W;
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_TCFG = 1, A_TCNT = 2, A_DATA = 3,
                                A_LVL = 4, A_IEN = 5, A_IST = 6;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [LVL_W-1:0]  cnt, cnt_nxt;
  logic [3:0]        ist, ien, ev, clr;
  logic              dma_mode, tmr_en;
  logic [TMR_W-1:0]  tmr_cnt, tmr_lim;

  wire flush    = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  wire dat_rd   = reg_rd && reg_addr == A_DATA;
  wire is_empty = cnt == '0;
  wire is_full  = cnt == LVL_W'(DEPTH);
  wire pop      = dat_rd && !is_empty;
  wire push     = smp_valid && (!is_full || pop);
  wire tmr_clr  = flush || (reg_wr && reg_addr == A_TCFG && reg_wdata[CFG_W]);

  assign cnt_nxt = cnt + LVL_W'(push) - LVL_W'(pop);
  assign ev  = {smp_valid && !push, dat_rd && is_empty,
                !is_empty && cnt_nxt == '0, !is_full && cnt_nxt == LVL_W'(DEPTH)};
  assign clr = (reg_wr && reg_addr == A_IST) ? reg_wdata[3:0] : 4'b0;

  assign fill_level = cnt;
  assign irq        = |(ist & ien);
  assign dma_req    = dma_mode && !is_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      ist    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      ist    <= '0;
    end else begin
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      cnt <= cnt_nxt;
      ist <= (ist & ~clr) | ev;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush)
      mem[wr_ptr] <= {STAMP_W'(tmr_cnt), smp_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= '0;
      dma_mode <= 1'b0;
      tmr_en   <= 1'b0;
      tmr_lim  <= '1;
    end else if (reg_wr) begin
      if (reg_addr == A_IEN)  ien      <= reg_wdata[3:0];
      if (reg_addr == A_CTRL) dma_mode <= reg_wdata[1];
      if (reg_addr == A_TCFG) begin
        tmr_en  <= reg_wdata[CFG_W+1];
        tmr_lim <= reg_wdata[TMR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmr_cnt <= '0;
    else if (tmr_clr)       tmr_cnt <= '0;
    else if (tmr_en)        tmr_cnt <= (tmr_cnt == tmr_lim) ? '0 : tmr_cnt + 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[1] = dma_mode;
      A_TCFG: begin
        reg_rdata[CFG_W+1]   = tmr_en;
        reg_rdata[TMR_W-1:0] = tmr_lim;
      end
      A_TCNT: reg_rdata[TMR_W-1:0] = tmr_cnt;
      A_DATA: reg_rdata = is_empty ? '0 : mem[rd_ptr];
      A_LVL:  reg_rdata[LVL_W-1:0] = cnt;
      A_IEN:  reg_rdata[3:0] = ien;
      A_IST:  reg_rdata[3:0] = ist;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsfifo_chan_chk.sv
module tsfifo_chan_chk #(
  parameter int LVL_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq,
  input logic             dma_req,
  input logic [LVL_W-1:0] fill_level,
  input logic [3:0]       ist
);
  wire c_flush = reg_wr && reg_addr == 3'd0 && reg_wdata[0];
  wire c_drd   = reg_rd && reg_addr == 3'd3;

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH));

  // R1
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_flush |=> (fill_level <= $past(fill_level) + 1'b1) && (fill_level + 1'b1 >= $past(fill_level)));

  // R4
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && fill_level == LVL_W'(DEPTH) && !c_drd && !c_flush |=> fill_level == LVL_W'(DEPTH) && ist[3]);

  // R5
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_drd && fill_level == '0 |-> reg_rdata == '0);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd6 && reg_wdata[3] && smp_valid && fill_level == LVL_W'(DEPTH) && !c_drd |=> ist[3]);

  // R10
  dma_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fill_level != '0);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_flush |=> fill_level == '0 && !irq && ist == '0);
endmodule

bind tsfifo_chan tsfifo_chan_chk u_chk (.*);

// File: tb/sim_tsfifo_chan.sv
module sim_tsfifo_chan;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dma_req;
  logic [2:0]  fill_level;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] q[$];
  int stat = 0, ien = 0, dma = 0, ten = 0, tlim = 'h1FFFF, tcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  tsfifo_chan u0 (.clk, .rst_n, .smp_valid, .smp_data, .reg_wr, .reg_rd, .reg_addr,
                  .reg_wdata, .reg_rdata, .irq, .dma_req, .fill_level);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {30'b0, dma[0], 1'b0};
      3'd1: return {6'b0, ten[0], 8'b0, tlim[16:0]};
      3'd2: return {15'b0, tcnt[16:0]};
      3'd3: return (q.size() == 0) ? 32'h0 : q[0];
      3'd4: return 32'(q.size());
      3'd5: return 32'(ien);
      3'd6: return 32'(stat);
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input bit sv, input logic [13:0] sd, input bit wr, input bit rd,
                     input logic [2:0] a, input logic [31:0] wd, input string tag);
    bit flush, dat, pop, push, ovf, unf, tclr;
    int old_n, new_n, setv, clrv;
    logic [31:0] word;
    smp_valid = sv; smp_data = sd; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) chk(tag, $sformatf("rdata@%0d", a), reg_rdata, exp_rd(a));
    flush = wr && a == 3'd0 && wd[0];
    dat   = rd && a == 3'd3;
    old_n = q.size();
    pop   = dat && old_n > 0;
    push  = sv && (old_n < 4 || pop);
    ovf   = sv && !push;
    unf   = dat && old_n == 0;
    new_n = old_n - int'(pop) + int'(push);
    setv  = (ovf ? 8 : 0) | (unf ? 4 : 0) | ((old_n != 0 && new_n == 0) ? 2 : 0) |
            ((old_n != 4 && new_n == 4) ? 1 : 0);
    clrv  = (wr && a == 3'd6) ? int'(wd[3:0]) : 0;
    word  = {1'b0, tcnt[16:0], sd};
    tclr  = flush || (wr && a == 3'd1 && wd[24]);
    if (flush) begin
      q.delete();
      stat = 0;
    end else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(word);
      stat = (stat & ~clrv) | setv;
    end
    if (tclr) tcnt = 0;
    else if (ten != 0) tcnt = (tcnt == tlim) ? 0 : tcnt + 1;
    if (wr && a == 3'd5) ien = int'(wd[3:0]);
    if (wr && a == 3'd0) dma = int'(wd[1]);
    if (wr && a == 3'd1) begin
      ten  = int'(wd[25]);
      tlim = int'(wd[16:0]);
    end
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0; reg_wr = 0; reg_rd = 0;
    chk(tag, "fill_level", 32'(fill_level), 32'(q.size()));
    chk(tag, "irq", 32'(irq), 32'((stat & ien) != 0));
    chk(tag, "dma_req", 32'(dma_req), 32'(dma != 0 && q.size() != 0));
  endtask

  task automatic idle(input string tag);          cyc(0, 0, 0, 0, 0, 0, tag); endtask
  task automatic put(input logic [13:0] d, input string tag); cyc(1, d, 0, 0, 0, 0, tag); endtask
  task automatic rd(input logic [2:0] a, input string tag);   cyc(0, 0, 0, 1, a, 0, tag); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag); cyc(0, 0, 1, 0, a, d, tag); endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12", "fill_level", 32'(fill_level), 0);
    chk("R12", "irq", 32'(irq), 0);
    chk("R12", "dma_req", 32'(dma_req), 0);
    for (int a = 0; a < 8; a++) if (a != 3) rd(3'(a), "R12");

    // R3 start timer, limit 9, watch wrap
    wr(1, 32'h0200_0009, "R3");
    for (int i = 0; i < 12; i++) rd(2, "R3");

    // R1 R2 fill the buffer with stamped samples
    put(14'h1234, "R2");
    idle("R1");
    put(14'h0ABC, "R2");
    put(14'h3FFF, "R2");
    rd(4, "R1");
    put(14'h0001, "R6");
    rd(6, "R6");
    // R4 overflow drop
    put(14'h2222, "R4");
    rd(6, "R4");
    rd(4, "R4");
    // R7 write-1-to-clear full bit, zero write no effect
    wr(6, 32'h1, "R7");
    rd(6, "R7");
    wr(6, 32'h0, "R7");
    rd(6, "R7");
    // R8 event and clear in the same cycle
    cyc(1, 14'h0555, 1, 0, 6, 32'h8, "R8");
    rd(6, "R8");
    // R4 push with pop while full
    cyc(1, 14'h0777, 0, 1, 3, 0, "R4");
    rd(4, "R4");
    // R9 interrupt masking
    wr(5, 32'h8, "R9");
    wr(5, 32'h2, "R9");
    // R10 DMA mode
    wr(0, 32'h2, "R10");
    rd(0, "R10");
    // R1 R2 drain; R6 empty event
    for (int i = 0; i < 4; i++) rd(3, "R1");
    rd(6, "R6");
    // R5 underflow
    rd(3, "R5");
    rd(6, "R5");
    wr(6, 32'hF, "R7");
    // R3 reset bit and ignored upper limit bits
    wr(1, 32'h03FE_0005, "R3");
    rd(1, "R3");
    for (int i = 0; i < 9; i++) rd(2, "R3");
    put(14'h0042, "R2");
    put(14'h0043, "R2");
    // R11 flush with a colliding sample
    wr(5, 32'hF, "R11");
    cyc(1, 14'h0099, 1, 0, 0, 32'h3, "R11");
    rd(2, "R11");
    rd(6, "R11");
    rd(4, "R11");
    // R3 stop timer
    wr(1, 32'h0000_0005, "R3");
    rd(2, "R3");
    rd(2, "R3");
    // R1 R4 R6 R7 mixed traffic
    for (int i = 0; i < 300; i++) begin
      bit sv = (i * 7) % 3 != 0;
      bit r  = (i * 5) % 4 == 1;
      bit w  = i % 11 == 0;
      cyc(sv, 14'(i * 37), w, r, w ? 3'd6 : 3'd3, 32'(i % 16), "R1");
    end
    wr(1, 32'h0200_0003, "R3");
    for (int i = 0; i < 40; i++) begin
      bit sv = i % 2 == 0;
      bit r  = i % 3 == 0;
      cyc(sv, 14'(i * 91), 0, r, 3, 0, "R2");
    end
    rd(6, "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule